// File: doc/BRIEF.md
# SPI EEPROM Target Model

This block is a synthesizable stand-in for a small serial EEPROM that sits on an SPI bus as a target. An external host drives chip select, serial clock, serial data in, a hold input and a write-protect input. The block returns data on a serial output that has its own output-enable. The byte array (4096 x 8 by default) is held in internal registers. The system clock `clk` oversamples every bus pin through a synchronizer, so the serial clock must run well below `clk`: each SCK level has to last at least four `clk` cycles.

The host sends an 8-bit command and, where the command needs one, a 16-bit address. The commands are array read with an auto-incrementing address, write-enable latch set and clear, page write, status read and status write. Writes land in a page-sized staging buffer and reach the array only when chip select rises cleanly at a byte boundary. The write then starts a self-timed busy period whose length is a parameter in `clk` cycles. Three things gate a write: a write-enable latch that clears itself, two block-protect bits, and the write-protect pin, which can lock the status register.

Top module: `eespi_target`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0xFF, and `miso_oe` stays low whenever `cs_n` has been high for more than the synchronizer depth. Raising `cs_n` aborts any command and returns the block to waiting for an opcode.
- R2: `mosi` is taken on SCK rising edges and `miso` changes only after SCK falling edges, most significant bit first (SPI mode 0/3). `miso_oe` is high only while array data or the status byte is being shifted out.
- R3: Opcode 0x03 followed by a 16-bit address returns the byte at that address, then keeps returning following bytes. The address steps by one per byte and wraps from 0xFFF to 0x000.
- R4: Only the low 12 address bits are used. The upper 4 address bits have no effect on which byte is read or written.
- R5: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it.
- R6: A write (opcode 0x02) or a status write (opcode 0x01) given while the write-enable latch is clear is ignored: the array and the status stay unchanged.
- R7: Page-write data lands at successive offsets inside the 32-byte page that holds the start address and wraps from offset 31 to offset 0 of the same page. When more than 32 bytes are sent, later bytes replace earlier ones in the same slot.
- R8: A write is committed only when `cs_n` rises after a whole number of data bytes, at least one. Otherwise nothing is written and the write-enable latch keeps its value.
- R9: A committed write, to the array or to the status register, holds status bit 0 (write in progress) at 1 for WRITE_CYCLES clock cycles. While that bit is 1, only the status read is accepted and every other command is ignored. The write-enable latch clears when the period ends.
- R10: Status bits 3:2 choose the protected area: 00 none, 01 addresses 0xC00 to 0xFFF, 10 addresses 0x800 to 0xFFF, 11 the whole array. A page write that starts in a protected area changes nothing, starts no busy period and leaves the latch set.
- R11: A status write loads status bits 7 (protect-enable), 3 and 2. It is refused when bit 7 is already 1 and `wp_n` is low; with `wp_n` high it proceeds.
- R12: While `hold_n` is low, SCK edges are ignored and `miso_oe` is low. When `hold_n` returns high, the transfer resumes at the bit where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause input, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; low means high-impedance |

## Verification
The bound checker watches four things on every cycle. The output is released during deselect and during hold. A busy period never begins unless the latch was set. A busy period begins only in the cycle after chip select rises. The latch is always clear once the busy period ends. The bench's scenarios are the only place where the data-path behaviours show up: the address wrap of a sequential read, the page wrap and slot overwrite of a long write, the refused partial-byte commit, the protected-area boundaries, the pin lock of the status register and a correct resume after hold. Each of these is compared against a behavioural array-and-status model held in the bench.

// File: rtl/eespi_pkg.sv
package eespi_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_RDATA,
      ST_WDATA,
      ST_RDSR,
      ST_WRSR,
      ST_SKIP
   } ee_state_e;

   localparam logic [7:0] OPC_WRSR  = 8'h01;
   localparam logic [7:0] OPC_WRITE = 8'h02;
   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_WRDI  = 8'h04;
   localparam logic [7:0] OPC_RDSR  = 8'h05;
   localparam logic [7:0] OPC_WREN  = 8'h06;

endpackage

// File: rtl/eespi_sync.sv
// Multi-stage synchronizer for a vector of asynchronous bus pins.
module eespi_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/eespi_timer.sv
// Self-timed write period counter.
module eespi_timer #(
   parameter int unsigned CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int unsigned CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt <= '0;
      else if (start && cnt == '0)   cnt <= CW'(CYCLES);
      else if (cnt != '0)            cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));
endmodule

// File: rtl/eespi_protect.sv
// Decodes the two block-protect bits against a page number.
module eespi_protect #(
   parameter int unsigned PG_W = 7
) (
   input  logic [1:0]      bp,
   input  logic [PG_W-1:0] page,
   output logic            prot
);
   logic [1:0] top2;
   assign top2 = page[PG_W-1 -: 2];

   always_comb begin
      unique case (bp)
         2'b00:   prot = 1'b0;
         2'b01:   prot = (top2 == 2'b11);
         2'b10:   prot = top2[1];
         default: prot = 1'b1;
      endcase
   end
endmodule

// File: rtl/eespi_target.sv
module eespi_target
   import eespi_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned PAGE_W       = 5,
   parameter int unsigned WRITE_CYCLES = 250000,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter logic [7:0]  ERASED       = 8'hFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic mosi,
   input  logic hold_n,
   input  logic wp_n,
   output logic miso,
   output logic miso_oe
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned PAGE  = 1 << PAGE_W;
   localparam int unsigned PG_W  = ADDR_W - PAGE_W;
   localparam int unsigned HI_W  = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 9..16");
      end
      if (PAGE_W < 1 || PG_W < 2) begin : g_bad_page
         $error("PAGE_W must leave at least two page-number bits");
      end
      if (WRITE_CYCLES < 1 || SYNC_STAGES < 2) begin : g_bad_misc
         $error("WRITE_CYCLES >= 1 and SYNC_STAGES >= 2 required");
      end
   endgenerate

   // ---------------- pin synchronization and edge detection
   logic [4:0] sv;
   eespi_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({cs_n, hold_n, wp_n, sck, mosi}),
      .q(sv)
   );
   logic cs_s, hold_s, wp_s, sck_s, mosi_s;
   assign {cs_s, hold_s, wp_s, sck_s, mosi_s} = sv;

   logic cs_p, sck_p;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_p  <= 1'b1;
         sck_p <= 1'b0;
      end else begin
         cs_p  <= cs_s;
         sck_p <= sck_s;
      end
   end

   logic active, sck_rise, sck_fall, cs_rise;
   assign active   = !cs_s && hold_s;
   assign sck_rise = active && sck_s && !sck_p;
   assign sck_fall = active && !sck_s && sck_p;
   assign cs_rise  = cs_s && !cs_p;

   // ---------------- state
   ee_state_e          state;
   logic [2:0]         bit_cnt;
   logic [6:0]         shreg;
   logic               addr_ph, is_wr;
   logic [HI_W-1:0]    addr_hi;
   logic [ADDR_W-1:0]  addr;
   logic [7:0]         rd_byte;
   logic               miso_q;
   logic               wel, wpen, sr_got, sr_n_wpen;
   logic [1:0]         bp, sr_n_bp;
   logic [PG_W-1:0]    wpage;
   logic [PAGE_W-1:0]  wptr;
   logic [7:0]         wbuf [PAGE];
   logic [PAGE-1:0]    wvalid;
   logic [7:0]         mem  [DEPTH];

   logic busy, wr_done, prot;
   logic arr_commit, sr_commit;

   logic [7:0]        byte_in, status;
   logic [ADDR_W-1:0] full_addr;
   assign byte_in   = {shreg, mosi_s};
   assign status    = {wpen, 3'b000, bp, wel, busy};
   assign full_addr = {addr_hi, byte_in};

   eespi_protect #(.PG_W(PG_W)) u_prot (.bp(bp), .page(wpage), .prot(prot));

   assign arr_commit = cs_rise && state == ST_WDATA && bit_cnt == 3'd0
                       && (|wvalid) && !prot;
   assign sr_commit  = cs_rise && state == ST_WRSR && bit_cnt == 3'd0 && sr_got;

   eespi_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(arr_commit || sr_commit),
      .busy(busy), .done(wr_done)
   );

   // ---------------- command engine
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_CMD;
         bit_cnt <= '0;
         shreg   <= '0;
         addr_ph <= 1'b0;
         is_wr   <= 1'b0;
         addr_hi <= '0;
         addr    <= '0;
         rd_byte <= '0;
         miso_q  <= 1'b0;
         wel     <= 1'b0;
         wpen    <= 1'b0;
         bp      <= 2'b00;
         sr_got  <= 1'b0;
         sr_n_wpen <= 1'b0;
         sr_n_bp <= 2'b00;
         wpage   <= '0;
         wptr    <= '0;
         wvalid  <= '0;
         for (int i = 0; i < PAGE; i++) wbuf[i] <= '0;
      end else begin
         if (wr_done) wel <= 1'b0;
         if (sr_commit) begin
            wpen <= sr_n_wpen;
            bp   <= sr_n_bp;
         end
         if (cs_s) begin
            state   <= ST_CMD;
            bit_cnt <= '0;
         end else if (sck_rise) begin
            shreg   <= byte_in[6:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) begin
               unique case (state)
                  ST_CMD: begin
                     state <= ST_SKIP;
                     if (byte_in == OPC_READ && !busy) begin
                        state <= ST_ADDR; is_wr <= 1'b0; addr_ph <= 1'b0;
                     end else if (byte_in == OPC_WRITE && !busy && wel) begin
                        state <= ST_ADDR; is_wr <= 1'b1; addr_ph <= 1'b0;
                        wvalid <= '0;
                     end else if (byte_in == OPC_WREN && !busy) begin
                        wel <= 1'b1;
                     end else if (byte_in == OPC_WRDI && !busy) begin
                        wel <= 1'b0;
                     end else if (byte_in == OPC_RDSR) begin
                        state <= ST_RDSR; rd_byte <= status;
                     end else if (byte_in == OPC_WRSR && !busy && wel
                                  && !(wpen && !wp_s)) begin
                        state <= ST_WRSR; sr_got <= 1'b0;
                     end
                  end
                  ST_ADDR: begin
                     if (!addr_ph) begin
                        addr_ph <= 1'b1;
                        addr_hi <= byte_in[HI_W-1:0];
                     end else if (is_wr) begin
                        wpage <= full_addr[ADDR_W-1:PAGE_W];
                        wptr  <= full_addr[PAGE_W-1:0];
                        state <= ST_WDATA;
                     end else begin
                        rd_byte <= mem[full_addr];
                        addr    <= full_addr + 1'b1;
                        state   <= ST_RDATA;
                     end
                  end
                  ST_RDATA: begin
                     rd_byte <= mem[addr];
                     addr    <= addr + 1'b1;
                  end
                  ST_WDATA: begin
                     wbuf[wptr]   <= byte_in;
                     wvalid[wptr] <= 1'b1;
                     wptr         <= wptr + 1'b1;
                  end
                  ST_RDSR: rd_byte <= status;
                  ST_WRSR: begin
                     sr_got    <= 1'b1;
                     sr_n_wpen <= byte_in[7];
                     sr_n_bp   <= byte_in[3:2];
                  end
                  default: ;
               endcase
            end
         end
         if (sck_fall && (state == ST_RDATA || state == ST_RDSR))
            miso_q <= rd_byte[3'd7 - bit_cnt];
      end
   end

   // ---------------- array update at commit
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= ERASED;
      end else if (arr_commit) begin
         for (int i = 0; i < PAGE; i++)
            if (wvalid[i]) mem[{wpage, PAGE_W'(i)}] <= wbuf[i];
      end
   end

   assign miso    = miso_q;
   assign miso_oe = active && (state == ST_RDATA || state == ST_RDSR);
endmodule

// File: rtl/eespi_target_chk.sv
module eespi_target_chk #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic hold_n,
   input logic miso_oe,
   input logic busy,
   input logic wel,
   input logic cs_rise
);
   logic [3:0] cs_hi_cnt, hold_lo_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_hi_cnt   <= '0;
         hold_lo_cnt <= '0;
      end else begin
         cs_hi_cnt   <= !cs_n   ? '0 : (cs_hi_cnt   == 4'hF ? cs_hi_cnt   : cs_hi_cnt + 1'b1);
         hold_lo_cnt <= hold_n  ? '0 : (hold_lo_cnt == 4'hF ? hold_lo_cnt : hold_lo_cnt + 1'b1);
      end
   end

   assert_idle_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cs_hi_cnt) > SYNC_STAGES) |-> !miso_oe);

   assert_hold_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(hold_lo_cnt) > SYNC_STAGES) |-> !miso_oe);

   assert_start_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> wel);

   assert_commit_on_cs_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_rise));

   assert_wel_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);
endmodule

bind eespi_target eespi_target_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
   .miso_oe(miso_oe), .busy(busy), .wel(wel), .cs_rise(cs_rise)
);

// File: tb/eespi_target_tb.sv
module eespi_target_tb;
   localparam int WCYC = 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic miso, miso_oe;

   always #10 clk = ~clk;

   eespi_target #(.WRITE_CYCLES(WCYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // behavioural reference
   logic [7:0] ref_mem [4096];
   bit ref_wel = 0, ref_wpen = 0;
   bit [1:0] ref_bp = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-clock check: output released when deselected or held (R1, R12)
   int quiet = 0;
   logic last_cs = 1'b1, last_hold = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_n != last_cs || hold_n != last_hold) quiet = 0;
         else if (quiet < 100) quiet++;
         last_cs = cs_n; last_hold = hold_n;
         if ((cs_n || !hold_n) && quiet >= 4) begin
            checks++;
            if (miso_oe !== 1'b0) begin
               errors++;
               $display("FAIL R1/R12 miso_oe actual=%b expected=0", miso_oe);
            end
         end
      end
   end

   function automatic bit is_prot(input bit [1:0] b, input logic [11:0] a);
      case (b)
         2'b00: return 0;
         2'b01: return a[11:10] == 2'b11;
         2'b10: return a[11];
         default: return 1;
      endcase
   endfunction

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe);
      rx = '0; oe = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         repeat (4) @(negedge clk);
         rx[i] = miso; oe &= miso_oe;
         sck = 1'b1;
         repeat (4) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic cs_lo(); cs_n = 1'b0; repeat (4) @(negedge clk); endtask
   task automatic cs_hi(); repeat (4) @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk); endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r; logic o;
      cs_lo(); xfer(op, r, o); cs_hi();
   endtask

   task automatic wren(); cmd1(8'h06); ref_wel = 1; endtask
   task automatic wrdi(); cmd1(8'h04); ref_wel = 0; endtask
   task automatic wait_wr(); repeat (WCYC + 20) @(negedge clk); endtask

   task automatic rdsr_chk(input string tag, input logic [7:0] exp);
      logic [7:0] r; logic o;
      cs_lo(); xfer(8'h05, r, o); xfer(8'h00, r, o); cs_hi();
      chk(tag, {o, r}, {1'b1, exp});
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] r; logic o;
      cs_lo(); xfer(8'h01, r, o); xfer(v, r, o); cs_hi();
      if (ref_wel && !(ref_wpen && !wp_n)) begin
         ref_wpen = v[7]; ref_bp = v[3:2];
         wait_wr(); ref_wel = 0;
      end
   endtask

   // page write of n bytes; extra_bits > 0 leaves a partial byte
   task automatic pwrite(input logic [15:0] a, input int n, input logic [7:0] seed,
                         input int extra_bits, input bit wait_done);
      logic [7:0] r; logic o;
      bit commit;
      cs_lo();
      xfer(8'h02, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
      for (int k = 0; k < n; k++) xfer(seed + 8'(k * 7), r, o);
      for (int b = 0; b < extra_bits; b++) begin
         mosi = b[0]; repeat (4) @(negedge clk); sck = 1'b1;
         repeat (4) @(negedge clk); sck = 1'b0;
      end
      cs_hi();
      commit = ref_wel && n > 0 && extra_bits == 0 && !is_prot(ref_bp, a[11:0]);
      if (commit) begin
         for (int k = 0; k < n; k++)
            ref_mem[{a[11:5], 5'(a[4:0] + 5'(k))}] = seed + 8'(k * 7);
         if (wait_done) begin wait_wr(); ref_wel = 0; end
      end
   endtask

   task automatic rd_chk(input string tag, input logic [15:0] a, input int n);
      logic [7:0] r; logic o;
      cs_lo();
      xfer(8'h03, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, r, o);
         chk(tag, {o, r}, {1'b1, ref_mem[12'(a[11:0] + 12'(k))]});
      end
      cs_hi();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r; logic o;
      for (int i = 0; i < 4096; i++) ref_mem[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: reset state
      rdsr_chk("R1 status after reset", 8'h00);
      rd_chk("R1 erased array", 16'h0000, 2);

      // R6: write without latch ignored
      pwrite(16'h0100, 2, 8'h11, 0, 1);
      rd_chk("R6 write without WEL", 16'h0100, 2);

      // R5: latch set / clear
      wren();
      rdsr_chk("R5 WEL set", 8'h02);
      wrdi();
      rdsr_chk("R5 WEL cleared", 8'h00);

      // R9 + R2/R3: page write, busy visible, then readback
      wren();
      pwrite(16'h0105, 4, 8'h5A, 0, 0);
      rdsr_chk("R9 WIP during write", 8'h03);
      cs_lo();
      xfer(8'h03, r, o); xfer(8'h01, r, o); xfer(8'h05, r, o); xfer(8'h00, r, o);
      cs_hi();
      chk("R9 read refused while busy", o, 1'b0);
      wait_wr(); ref_wel = 0;
      rdsr_chk("R9 WIP and WEL clear after write", 8'h00);
      rd_chk("R3 sequential read", 16'h0104, 6);
      rd_chk("R4 upper address bits ignored", 16'hF105, 2);

      // R7: page wrap and slot overwrite
      wren();
      pwrite(16'h021E, 6, 8'h30, 0, 1);
      rd_chk("R7 page wrap", 16'h0200, 32);
      wren();
      pwrite(16'h0500, 34, 8'h80, 0, 1);
      rd_chk("R7 slot overwrite", 16'h0500, 3);

      // R3: read address wraps at the array end
      wren(); pwrite(16'h0000, 2, 8'hC1, 0, 1);
      wren(); pwrite(16'h0FFE, 2, 8'hD3, 0, 1);
      rd_chk("R3 read wrap at end", 16'h0FFE, 4);

      // R8: partial byte prevents commit
      wren();
      pwrite(16'h0400, 1, 8'hAA, 3, 1);
      rdsr_chk("R8 WEL kept after aborted write", 8'h02);
      rd_chk("R8 array untouched", 16'h0400, 1);
      wrdi();

      // R10: block protection levels
      wren(); wrsr(8'h04);
      rdsr_chk("R10 bp=01 loaded", 8'h04);
      wren(); pwrite(16'h0C10, 2, 8'h44, 0, 1);
      rdsr_chk("R10 protected write leaves WEL", 8'h06);
      pwrite(16'h0B10, 2, 8'h55, 0, 1);
      rd_chk("R10 upper quarter protected", 16'h0C10, 2);
      rd_chk("R10 below quarter writable", 16'h0B10, 2);
      wren(); wrsr(8'h08);
      wren(); pwrite(16'h0810, 1, 8'h66, 0, 1);
      rd_chk("R10 upper half protected", 16'h0810, 1);
      pwrite(16'h07F0, 1, 8'h67, 0, 1);
      rd_chk("R10 lower half writable", 16'h07F0, 1);
      wren(); wrsr(8'h0C);
      wren(); pwrite(16'h0010, 1, 8'h77, 0, 1);
      rd_chk("R10 whole array protected", 16'h0010, 1);
      wrsr(8'h00);
      rdsr_chk("R10 protection cleared", 8'h00);

      // R11: write-protect pin locks the status register
      wren(); wrsr(8'h80);
      rdsr_chk("R11 protect-enable set", 8'h80);
      wp_n = 1'b0;
      wren(); wrsr(8'h0C);
      rdsr_chk("R11 status write refused", 8'h82);
      wp_n = 1'b1;
      wrsr(8'h00);
      rdsr_chk("R11 status write with pin high", 8'h00);

      // R12: hold pause in the middle of a read
      cs_lo();
      xfer(8'h03, r, o); xfer(8'h02, r, o); xfer(8'h00, r, o);
      xfer(8'h00, r, o);
      chk("R12 byte before hold", r, ref_mem[12'h200]);
      mosi = 1'b0;
      repeat (2) @(negedge clk);
      hold_n = 1'b0;
      repeat (6) @(negedge clk);
      for (int t = 0; t < 3; t++) begin
         sck = 1'b1; repeat (4) @(negedge clk);
         chk("R12 output released in hold", miso_oe, 1'b0);
         sck = 1'b0; repeat (4) @(negedge clk);
      end
      hold_n = 1'b1;
      repeat (6) @(negedge clk);
      xfer(8'h00, r, o);
      chk("R12 resume after hold", {o, r}, {1'b1, ref_mem[12'h201]});
      xfer(8'h00, r, o);
      chk("R12 next byte after hold", {o, r}, {1'b1, ref_mem[12'h202]});
      cs_hi();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule